// File: doc/BRIEF.md
# Switchable Machine-Cycle Clock Prescaler with Address Strobe

This block turns a raw oscillator clock into the timing a small 8-bit core needs: a core clock enable and a machine-cycle state number that runs through six states. In standard speed the oscillator is first halved, so one state takes two oscillator clocks and a machine cycle takes twelve. In double speed the halving stage is bypassed, so one state takes one oscillator clock and a machine cycle takes six. The speed choice is a register bit. A change of that bit is taken only on a rising edge of the half-rate clock, so the core enable never forms a runt or a stretched gap while the speed changes under a running core.

The block also drives the address-latch strobe. The strobe is high in two of the six states, so it pulses twice per machine cycle: once every 6 oscillator clocks in standard speed and once every 3 in double speed. A per-cycle flag marks a machine cycle that moves data to or from external memory. The flag is sampled when the machine cycle starts. In a flagged cycle the second strobe pulse is dropped. A strobe-off bit keeps the strobe low in all cycles except flagged ones.

Top module: `mc_clock_gen`

## Requirements
- R1: While reset is asserted, core_en, mc_phase and ale are all 0.
- R2: In standard speed (dbl_speed at 0, the reset value), core_en is high on every second oscillator clock. That gives 12 enables in any 24 consecutive oscillator clocks.
- R3: In double speed (dbl_speed at 1), core_en is high on every oscillator clock.
- R4: A new dbl_speed value is taken only at an oscillator edge where the half-rate clock rises. In standard speed the half-rate clock rises at the edge that follows a low core_en, and never at the edge that follows a high core_en. A one-clock pulse at the edge that follows a high core_en is ignored. Around any speed change, the gap between two core enables is always one or two oscillator clocks.
- R5: mc_phase takes the values 0 to 5. It advances by one, wrapping from 5 to 0, at each oscillator edge where core_en was high, and holds its value otherwise.
- R6: Every machine cycle takes twelve oscillator clocks in standard speed and six in double speed.
- R7: ale is high exactly while mc_phase is 1 or 4 (when the cycle is not flagged and ale_off is 0). The result is a steady strobe with a period of 6 oscillator clocks in standard speed and 3 in double speed.
- R8: In a machine cycle marked as an external data transfer, the state-4 pulse is dropped and only the state-1 pulse appears.
- R9: With ale_off at 1, ale stays low in unflagged machine cycles. In flagged cycles it still gives its state-1 pulse.
- R10: xfer_cycle is sampled once per machine cycle, at the edge where mc_phase wraps to 0. A change in the middle of a cycle has no effect until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbl_speed | input | 1 | Speed select: 0 = standard (12 clocks/cycle), 1 = double (6 clocks/cycle) |
| ale_off | input | 1 | 1 = strobe suppressed except in flagged transfer cycles |
| xfer_cycle | input | 1 | Marks the coming machine cycle as an external data/code transfer |
| core_en | output | 1 | Core clock enable, one per machine state |
| mc_phase | output | $clog2(STATES) (3) | Current machine-cycle state, 0 to STATES-1 |
| ale | output | 1 | Address-latch strobe |

## Verification
Two events can land on the same clock. The first is the acceptance of a speed change. The second is the state advance and strobe edge driven by the same enable. The bench raises dbl_speed at a clock where the half-rate edge is due and at a clock where it is not, and infers that from the visible enable pattern. A reference model of the state and strobe then runs on every cycle, and it checks that the enable gaps stay one or two clocks and that state steps and strobe levels stay correct through the switch. The second overlap is the start of a machine cycle, where the transfer flag is latched at the same edge as the state wraps. The bench moves the flag in the middle of a cycle and judges whether the state-4 pulse of the current cycle and of the next cycle follow the latched value.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    // state of the oscillator-rate divider
    typedef struct packed {
        logic tog;   // half-rate clock level
        logic fast;  // accepted speed mode
        logic en;    // core enable
    } div_state_t;

endpackage

// File: rtl/mcg_rate_div.sv
module mcg_rate_div
    import mcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fast_req,
    output logic core_en,
    output logic fast_mode
);

    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tog  = ~st_q.tog;
        // half-rate clock rises at this edge: only then may speed change
        if (!st_q.tog) begin
            st_d.fast = fast_req;
        end
        st_d.en   = st_d.fast | st_d.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_en   = st_q.en;
    assign fast_mode = st_q.fast;

    AST_SWITCH_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fast != $past(st_q.fast)) |-> !$past(st_q.tog)); // R4

    AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> st_q.en); // R2

endmodule

// File: rtl/mcg_phase_ctr.sv
module mcg_phase_ctr #(
    parameter int STATES  = 6,
    parameter int PHASE_W = $clog2(STATES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_en,
    input  logic               xfer_req,
    output logic [PHASE_W-1:0] phase,
    output logic [PHASE_W-1:0] phase_nxt,
    output logic               xfer_lat,
    output logic               xfer_nxt
);

    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(STATES - 1);

    typedef struct packed {
        logic [PHASE_W-1:0] ph;
        logic               xf;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (core_en) begin
            if (st_q.ph == LAST) begin
                st_d.ph = '0;
                st_d.xf = xfer_req;   // sampled at machine-cycle start
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.ph;
    assign phase_nxt = st_d.ph;
    assign xfer_lat  = st_q.xf;
    assign xfer_nxt  = st_d.xf;

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph <= LAST); // R5

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> $stable(st_q.ph)); // R5

    AST_XFER_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != '0) |-> $stable(st_q.xf)); // R10

endmodule

// File: rtl/mcg_strobe.sv
module mcg_strobe #(
    parameter int STATES  = 6,
    parameter int PHASE_W = $clog2(STATES),
    parameter int PH_A    = 1,
    parameter int PH_B    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_nxt,
    input  logic               xfer_nxt,
    input  logic [PHASE_W-1:0] phase,
    input  logic               xfer_lat,
    input  logic               strobe_off,
    output logic               ale
);

    localparam logic [PHASE_W-1:0] SA = PHASE_W'(PH_A);
    localparam logic [PHASE_W-1:0] SB = PHASE_W'(PH_B);

    typedef struct packed {
        logic ale;
    } stb_state_t;

    stb_state_t st_d, st_q;

    always_comb begin
        st_d.ale = 1'b0;
        if (phase_nxt == SA) begin
            st_d.ale = !strobe_off || xfer_nxt;
        end else if (phase_nxt == SB) begin
            st_d.ale = !strobe_off && !xfer_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ale = st_q.ale;

    AST_ALE_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ale |-> (phase == SA || phase == SB)); // R7

    AST_ALE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ale && phase == SB) |-> !xfer_lat); // R8

    AST_ALE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ale && $past(strobe_off)) |-> xfer_lat); // R9

endmodule

// File: rtl/mc_clock_gen.sv
module mc_clock_gen #(
    parameter int STATES  = 6,
    parameter int PH_A    = 1,
    parameter int PH_B    = 4,
    parameter int PHASE_W = $clog2(STATES)
) (
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic               dbl_speed,
    input  logic               ale_off,
    input  logic               xfer_cycle,
    output logic               core_en,
    output logic [PHASE_W-1:0] mc_phase,
    output logic               ale
);

    logic               fast_mode;
    logic [PHASE_W-1:0] phase_nxt;
    logic               xfer_lat;
    logic               xfer_nxt;

    mcg_rate_div u_div (
        .clk       (osc_clk),
        .rst_n     (rst_n),
        .fast_req  (dbl_speed),
        .core_en   (core_en),
        .fast_mode (fast_mode)
    );

    mcg_phase_ctr #(.STATES(STATES), .PHASE_W(PHASE_W)) u_ctr (
        .clk       (osc_clk),
        .rst_n     (rst_n),
        .core_en   (core_en),
        .xfer_req  (xfer_cycle),
        .phase     (mc_phase),
        .phase_nxt (phase_nxt),
        .xfer_lat  (xfer_lat),
        .xfer_nxt  (xfer_nxt)
    );

    mcg_strobe #(.STATES(STATES), .PHASE_W(PHASE_W), .PH_A(PH_A), .PH_B(PH_B)) u_stb (
        .clk        (osc_clk),
        .rst_n      (rst_n),
        .phase_nxt  (phase_nxt),
        .xfer_nxt   (xfer_nxt),
        .phase      (mc_phase),
        .xfer_lat   (xfer_lat),
        .strobe_off (ale_off),
        .ale        (ale)
    );

    AST_FAST_CONTINUOUS: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (fast_mode && $past(fast_mode)) |-> core_en); // R3

endmodule

// File: tb/mc_clock_gen_bench.sv
module mc_clock_gen_bench;

    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbl_speed = 1'b0;
    logic       ale_off = 1'b0;
    logic       xfer_cycle = 1'b0;
    logic       core_en;
    logic [2:0] mc_phase;
    logic       ale;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 osc_clk = ~osc_clk;

    mc_clock_gen u_mc_clock_gen (
        .osc_clk    (osc_clk),
        .rst_n      (rst_n),
        .dbl_speed  (dbl_speed),
        .ale_off    (ale_off),
        .xfer_cycle (xfer_cycle),
        .core_en    (core_en),
        .mc_phase   (mc_phase),
        .ale        (ale)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // ---------------- continuous reference model, sampled on negedge ----------
    bit       mon_on = 0;
    bit       mon_init = 0;
    bit       p_en;
    int       p_ph;
    bit       p_xf;
    bit       p_off;
    bit       lat_m;
    int       gap;

    always @(negedge osc_clk) begin
        if (mon_on) begin
            if (!mon_init) begin
                mon_init = 1;
                lat_m = 0;
                gap = 0;
            end else begin
                // R5 phase step
                chk(mc_phase == (p_en ? (p_ph + 1) % 6 : p_ph), "R5",
                    mc_phase, p_en ? (p_ph + 1) % 6 : p_ph);
                // R10 flag latch at cycle start
                if (p_en && p_ph == 5) lat_m = p_xf;
                // R7/R8/R9 strobe level
                begin
                    bit exp_ale;
                    exp_ale = (mc_phase == 1 && (!p_off || lat_m)) ||
                              (mc_phase == 4 && !p_off && !lat_m);
                    chk(ale == exp_ale, "R7/R8/R9", ale, exp_ale);
                end
                // R4 enable gap
                if (core_en) begin
                    chk(gap <= 1, "R4", gap, 1);
                    gap = 0;
                end else begin
                    gap++;
                end
            end
            p_en  = core_en;
            p_ph  = mc_phase;
            p_xf  = xfer_cycle;
            p_off = ale_off;
        end
    end

    // ---------------- helpers (drive at posedge + 2) ----------------
    task automatic step();
        @(posedge osc_clk);
        #2;
    endtask

    task automatic count_window(input int n, output int ens, output int rises);
        bit pa;
        ens = 0;
        rises = 0;
        pa = ale;
        for (int i = 0; i < n; i++) begin
            step();
            ens += core_en;
            if (ale && !pa) rises++;
            pa = ale;
        end
    endtask

    initial begin
        int e, r;
        // R1 reset state
        #1;
        repeat (3) begin
            #10;
            chk(core_en == 0, "R1", core_en, 0);
            chk(mc_phase == 0, "R1", mc_phase, 0);
            chk(ale == 0, "R1", ale, 0);
        end
        step();
        rst_n = 1'b1;
        mon_on = 1;
        repeat (10) step();

        // R2 standard speed
        count_window(24, e, r);
        chk(e == 12, "R2", e, 12);
        // R6 / R7 strobe period in standard speed
        count_window(48, e, r);
        chk(r == 8, "R7", r, 8);
        chk(e == 24, "R6", e, 24);

        // R4: pulse at a non-accepting edge is ignored
        while (!core_en) step();
        dbl_speed = 1'b1;
        step();
        dbl_speed = 1'b0;
        count_window(24, e, r);
        chk(e == 12, "R4 ignored pulse", e, 12);

        // R4: raise at an accepting edge, taken at once
        while (core_en) step();
        dbl_speed = 1'b1;
        step();
        chk(core_en == 1, "R4 accept", core_en, 1);
        step();
        chk(core_en == 1, "R4 accept", core_en, 1);
        // R3 double speed
        count_window(24, e, r);
        chk(e == 24, "R3", e, 24);
        count_window(48, e, r);
        chk(r == 16, "R7 double", r, 16);

        // back to standard at arbitrary points, gap monitor watches
        repeat (3) step();
        dbl_speed = 1'b0;
        repeat (4) step();
        count_window(24, e, r);
        chk(e == 12, "R2 after switch", e, 12);
        for (int k = 0; k < 6; k++) begin
            dbl_speed = ~dbl_speed;
            repeat (k + 1) step();
        end
        dbl_speed = 1'b0;
        repeat (4) step();

        // R8 flagged cycles, standard
        xfer_cycle = 1'b1;
        repeat (24) step();
        count_window(48, e, r);
        chk(r == 4, "R8", r, 4);

        // R9 strobe off
        ale_off = 1'b1;
        xfer_cycle = 1'b0;
        repeat (24) step();
        count_window(48, e, r);
        chk(r == 0, "R9 off", r, 0);
        xfer_cycle = 1'b1;
        repeat (24) step();
        count_window(48, e, r);
        chk(r == 4, "R9 flagged", r, 4);

        // R10 mid-cycle flag change
        ale_off = 1'b0;
        xfer_cycle = 1'b0;
        repeat (24) step();
        while (mc_phase != 2) step();
        xfer_cycle = 1'b1;
        while (mc_phase != 4) step();
        chk(ale == 1, "R10 current cycle", ale, 1);
        while (mc_phase != 0) step();
        while (mc_phase != 4) step();
        chk(ale == 0, "R10 next cycle", ale, 0);

        // R8 in double speed
        dbl_speed = 1'b1;
        repeat (12) step();
        count_window(48, e, r);
        chk(r == 8, "R8 double", r, 8);
        chk(e == 48, "R6 double", e, 48);

        repeat (4) step();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge osc_clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule